// File: doc/BRIEF.md
# MDIO Management Master

This block is a register-driven master for the two-wire PHY management interface defined in IEEE 802.3 clause 22. Software sees two 16-bit registers behind a simple write strobe, a select line and a combinational read path. The data register holds the value to send or the value most recently received. The command register holds a start flag, the direction, a clock-ratio code and the PHY and register addresses. A write to the command register while the engine is idle starts the engine. The engine then clocks out one complete management frame on the MDC and MDIO pins, or only a single MDC pulse when the start flag was written as zero.

MDC is derived from the system clock through a divider, and the 4-bit code in the command word chooses its ratio. Outgoing bits change on the falling edge of MDC. Incoming read bits are sampled on its rising edge. Software polls the start flag, which reads back as a busy indication, until it returns to zero. After a read, it then takes the PHY value from the data register.

Top module: `mdio_mgmt_master`

## Requirements
- R1: Command word bit fields are: bit 0 start/busy, bit 1 direction (1 = write to PHY, 0 = read), bits 5:2 divider code, bits 10:6 PHY register number, bits 15:11 PHY address. A command write while idle makes bit 0 of the command read-back equal 1 from the next cycle until the frame ends. Bits 15:1 read back as written.
- R2: A frame is PRE_BITS ones (default 32), then 0, 1, then opcode 1,0 for a read or 0,1 for a write, then PHY address and register number, each MSB first. The whole frame lasts PRE_BITS+32 MDC periods.
- R3: In a write frame the block drives the turnaround as 1,0, followed by the 16-bit data register value MSB first. MDIO output enable stays high for the whole frame.
- R4: In a read frame, output enable drops for the two turnaround bits and the 16 data bits. MDIO input is sampled at each MDC rising edge in the data bits. The 16 sampled bits, MSB first, are in the data register when busy clears.
- R5: The divider code gives MDC periods of 16, 26, 42, 62, 102 and 124 system clocks for codes 0 to 5. All other codes give 124. MDC is low for the first half-period after the start and high for the second half.
- R6: While busy, MDIO output and output enable change only in the cycle in which MDC falls.
- R7: Register writes, to either register, while busy have no effect on the frame in progress or on the register contents.
- R8: A command write with bit 0 clear produces exactly one MDC period with output enable low. Busy reads 1 during that period.
- R9: While idle, MDC is low and output enable is low.
- R10: After reset both registers read 0, MDC is low and output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 command, 1 data |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Read-back of the selected register |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input from the pin |

## Verification
The bench builds the block with the default 32-bit preamble. Full frames therefore run at their real length, and every divider code, including an unused one, stays inside the cycle budget. A timing model driven by elapsed cycles predicts MDC, the enable, each outgoing bit and the busy flag on every clock. A PHY model answers reads with a known pattern, so the check covers turnaround release and rising-edge capture. Writes that poke both registers in the middle of a frame, and the start-flag-clear pulse, are both covered at these settings.

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master #(
  parameter int PRE_BITS = 32,
  parameter int CNT_W    = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_sel,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  localparam int FRAME    = PRE_BITS + 32;
  localparam int BIT_W    = $clog2(FRAME + 1);
  localparam int TA_POS   = PRE_BITS + 14;
  localparam int DATA_POS = PRE_BITS + 16;

  logic [15:0]      cmd_q, data_q, rx_q;
  logic             active, mdc_q;
  logic [CNT_W-1:0] cnt_q;
  logic [BIT_W-1:0] bit_q;

  function automatic logic [CNT_W-1:0] half_of(input logic [3:0] code);
    case (code)
      4'd0:    half_of = CNT_W'(8);
      4'd1:    half_of = CNT_W'(13);
      4'd2:    half_of = CNT_W'(21);
      4'd3:    half_of = CNT_W'(31);
      4'd4:    half_of = CNT_W'(51);
      default: half_of = CNT_W'(62);
    endcase
  endfunction

  wire              is_wr    = cmd_q[1];
  wire              is_frame = cmd_q[0];
  wire [CNT_W-1:0]  half     = half_of(cmd_q[5:2]);
  wire [BIT_W-1:0]  last_bit = is_frame ? BIT_W'(FRAME - 1) : '0;
  wire [FRAME-1:0]  frame_w  = {{PRE_BITS{1'b1}}, 2'b01,
                                (is_wr ? 2'b01 : 2'b10),
                                cmd_q[15:11], cmd_q[10:6],
                                (is_wr ? 2'b10 : 2'b11),
                                (is_wr ? data_q : 16'hFFFF)};
  wire [BIT_W-1:0]  out_idx  = BIT_W'(FRAME - 1) - bit_q;

  assign reg_rdata = reg_sel ? data_q : {cmd_q[15:1], active};
  assign mdc       = mdc_q;
  assign mdio_o    = active ? frame_w[out_idx] : 1'b1;
  assign mdio_oe   = active && is_frame && (is_wr || (bit_q < BIT_W'(TA_POS)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      data_q <= '0;
      rx_q   <= '0;
      active <= 1'b0;
      mdc_q  <= 1'b0;
      cnt_q  <= '0;
      bit_q  <= '0;
    end else if (!active) begin
      if (reg_wr && !reg_sel) begin
        cmd_q  <= reg_wdata;
        active <= 1'b1;
        bit_q  <= '0;
        cnt_q  <= '0;
      end
      if (reg_wr && reg_sel)
        data_q <= reg_wdata;
    end else if (cnt_q == half - 1'b1) begin
      cnt_q <= '0;
      mdc_q <= ~mdc_q;
      if (mdc_q) begin
        if (bit_q == last_bit) begin
          active <= 1'b0;
          if (is_frame && !is_wr)
            data_q <= rx_q;
        end else begin
          bit_q <= bit_q + 1'b1;
        end
      end else if (is_frame && !is_wr && bit_q >= BIT_W'(DATA_POS)) begin
        rx_q <= {rx_q[14:0], mdio_i};
      end
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/mdio_mgmt_master_chk.sv
module mdio_mgmt_master_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr,
  input logic        reg_sel,
  input logic        active,
  input logic        mdc,
  input logic        mdio_o,
  input logic        mdio_oe,
  input logic [15:0] cmd_q,
  input logic [15:0] data_q
);
  assert_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !reg_sel && !active) |=> active);

  assert_out_on_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active) && !$fell(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));

  assert_cmd_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active)) |-> $stable(cmd_q));

  assert_data_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active)) |-> $stable(data_q));

  assert_pulse_released_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !cmd_q[0]) |-> !mdio_oe);

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (!mdc && !mdio_oe));
endmodule

bind mdio_mgmt_master mdio_mgmt_master_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .reg_wr  (reg_wr),
  .reg_sel (reg_sel),
  .active  (active),
  .mdc     (mdc),
  .mdio_o  (mdio_o),
  .mdio_oe (mdio_oe),
  .cmd_q   (cmd_q),
  .data_q  (data_q)
);

// File: tb/mdio_mgmt_master_bench.sv
module mdio_mgmt_master_bench;
  localparam int PRE   = 32;
  localparam int FRAME = PRE + 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_sel = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  int total = 0, bad = 0, cycles = 0;
  bit done = 0;

  // model state
  bit          m_pend = 0, m_run = 0, m_wr = 0, m_kick = 0;
  int          t = 0, h = 8, nb = FRAME;
  bit          fb[$];
  logic [15:0] m_rdval = '0;

  always #4 clk = ~clk;

  mdio_mgmt_master #(.PRE_BITS(PRE)) u_mdio_mgmt_master (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cycles);
    end
  endtask

  function automatic int half_for(input int code);
    case (code)
      0: return 8;   1: return 13;  2: return 21;
      3: return 31;  4: return 51;  default: return 62;
    endcase
  endfunction

  task automatic push_bits(input int val, input int n);
    for (int i = n - 1; i >= 0; i--) fb.push_back(bit'((val >> i) & 1));
  endtask

  always @(negedge clk) begin
    int b;
    bit e_mdc, e_oe;
    cycles++;
    if (m_pend) begin m_run = 1; t = 0; m_pend = 0; end
    else if (m_run) t++;
    b = t / (2 * h);
    e_mdc = 0;
    if (m_run) begin
      if (t >= 2 * h * nb) m_run = 0;
      else e_mdc = bit'((t / h) % 2);
    end
    e_oe = m_run && !m_kick && (m_wr || b < PRE + 14);
    if (rst_n) begin
      check(mdc == e_mdc, m_kick ? "R8 mdc" : "R5 mdc", mdc, e_mdc);
      check(mdio_oe == e_oe, m_kick ? "R8 oe" : (m_wr ? "R3 oe" : "R4 oe"), mdio_oe, e_oe);
      if (!reg_sel)
        check(reg_rdata[0] == m_run, m_kick ? "R8 busy" : "R1 busy", reg_rdata[0], m_run);
      if (e_oe && mdio_oe)
        check(mdio_o == fb[b], (b >= PRE + 14) ? "R3 data" : "R2 bit", mdio_o, fb[b]);
    end
    if (m_run && !m_wr && !m_kick && b >= PRE + 16)
      mdio_i = m_rdval[PRE + 31 - b];
    else
      mdio_i = 1'b1;
    if (cycles > 150000 && !done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic reg_write(input bit sel, input logic [15:0] d, input bit start);
    @(negedge clk); #1;
    reg_wr = 1; reg_sel = sel; reg_wdata = d;
    if (start) m_pend = 1;
    @(negedge clk); #1;
    reg_wr = 0; reg_sel = 0;
  endtask

  task automatic wait_idle();
    while (m_run || m_pend) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic read_reg(input bit sel, output logic [15:0] v);
    @(negedge clk); #1;
    reg_sel = sel;
    #1 v = reg_rdata;
    @(negedge clk); #1;
    reg_sel = 0;
  endtask

  task automatic run_frame(input bit wr, input int code, input int phy, input int rg,
                           input logic [15:0] d, input string req);
    logic [15:0] cmd, v;
    cmd = {phy[4:0], rg[4:0], code[3:0], wr, 1'b1};
    if (wr) reg_write(1, d, 0);
    fb.delete();
    push_bits(-1, PRE);
    push_bits(1, 2);
    push_bits(wr ? 1 : 2, 2);
    push_bits(phy, 5);
    push_bits(rg, 5);
    push_bits(wr ? 2 : 3, 2);
    push_bits(wr ? int'(d) : 16'hFFFF, 16);
    h = half_for(code); nb = FRAME; m_wr = wr; m_kick = 0; m_rdval = d;
    reg_write(0, cmd, 1);
    wait_idle();
    read_reg(1, v);
    check(v == d, wr ? "R3 data reg kept" : "R4 read data", v, d);
    read_reg(0, v);
    check(v == {cmd[15:1], 1'b0}, {req, " R1 readback"}, v, {cmd[15:1], 1'b0});
  endtask

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    read_reg(0, v); check(v == 0, "R10 cmd reset", v, 0);
    read_reg(1, v); check(v == 0, "R10 data reset", v, 0);
    check(mdc == 0 && mdio_oe == 0, "R10 pins", {mdc, mdio_oe}, 0);
    #1 rst_n = 1;
    repeat (3) @(negedge clk);
    check(mdc == 0 && mdio_oe == 0, "R9 idle pins", {mdc, mdio_oe}, 0);

    run_frame(1, 0, 5'h13, 5'h04, 16'hA5C3, "R2");
    run_frame(0, 0, 5'h01, 5'h1F, 16'h3C96, "R4");
    run_frame(1, 1, 5'h1E, 5'h00, 16'h8001, "R5 code1");
    run_frame(0, 2, 5'h0A, 5'h15, 16'hF00F, "R5 code2");
    run_frame(1, 3, 5'h00, 5'h11, 16'h7FFE, "R5 code3");
    run_frame(0, 4, 5'h1F, 5'h0E, 16'h1234, "R5 code4");
    run_frame(1, 5, 5'h07, 5'h02, 16'h0F0F, "R5 code5");
    run_frame(0, 9, 5'h15, 5'h0A, 16'hCAFE, "R5 unused");

    // R7: writes during a frame are ignored
    begin
      logic [15:0] cmd;
      cmd = {5'h09, 5'h06, 4'd0, 1'b1, 1'b1};
      reg_write(1, 16'hBEEF, 0);
      fb.delete();
      push_bits(-1, PRE); push_bits(1, 2); push_bits(1, 2);
      push_bits(5'h09, 5); push_bits(5'h06, 5); push_bits(2, 2); push_bits(16'hBEEF, 16);
      h = 8; nb = FRAME; m_wr = 1; m_kick = 0;
      reg_write(0, cmd, 1);
      repeat (100) @(negedge clk);
      reg_write(1, 16'h0000, 0);
      reg_write(0, 16'hFFFF, 0);
      reg_write(0, 16'h0000, 0);
      wait_idle();
      read_reg(1, v); check(v == 16'hBEEF, "R7 data unchanged", v, 16'hBEEF);
      read_reg(0, v); check(v == {cmd[15:1], 1'b0}, "R7 cmd unchanged", v, {cmd[15:1], 1'b0});
    end

    // R8: start flag clear gives one MDC pulse
    fb.delete(); fb.push_back(1);
    h = half_for(1); nb = 1; m_wr = 0; m_kick = 1;
    reg_write(0, {5'h03, 5'h03, 4'd1, 1'b0, 1'b0}, 1);
    wait_idle();
    read_reg(0, v); check(v[15:1] == {5'h03, 5'h03, 4'd1, 1'b0}, "R8 readback", v, {5'h03, 5'h03, 4'd1, 2'b00});
    m_kick = 0;
    repeat (4) @(negedge clk);
    check(mdc == 0 && mdio_oe == 0, "R9 idle after", {mdc, mdio_oe}, 0);

    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule